// File: doc/BRIEF.md
# Line Dark-Clamp Pixel Classifier

This block sits behind the digitizer of one horizontal readout register and sees that register's samples one line at a time. A line start marker comes with the first sample of every line. The block counts columns from that marker and gives each sample a tag. The first positions of a line are dummy shift stages. Next come the shielded dark columns, then the unshielded buffer columns, and then the active image columns. Anything sampled after the last real column is tagged as horizontal overclock. Samples that arrive before the first line marker after reset are also tagged as overclock.

Only the inner part of the dark band is trusted. The outermost dark column on each side is left out. The trusted samples are summed, and the sum is turned into a dark level with a fixed reciprocal multiply and rounding. That level is latched before the first active pixel of the same line. Each active pixel then leaves the block with the level subtracted, and the result saturates at zero. Every other sample leaves unchanged with its tag. If a new line marker arrives before the previous line reached its full length, a one-cycle short-line flag is raised.

Top module: `hline_dark_clamp`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` and `err_short` are 0.
- R2: Each accepted sample produces exactly one output sample one clock later. The tag depends on the column index, where the sample carrying `in_sol` is column 0. Columns 0..10 are dummy (tag 0). Columns 11..32 are dark (tag 1). Columns 33..44 are buffer (tag 2). Columns 45..2492 are active (tag 3). Column 2493 and later are overclock (tag 4).
- R3: Dummy, dark, buffer and overclock samples are output with their input data unchanged.
- R4: The dark level of a line is computed from the 20 trusted dark samples at columns 12..31, whose sum is S, as level = (S*3277 + 32768) >> 16.
- R5: An active sample is output as its input value minus the dark level of the same line. When that difference would be negative, the output is 0.
- R6: Dummy samples, the two outer dark columns (11 and 32), buffer samples and overclock samples have no effect on the dark level.
- R7: A line start marker resets both the column count and the dark accumulator. The dark level used in a line comes only from that line's own trusted samples.
- R8: When a sample with `in_sol` is accepted, `err_short` is 1 on that sample's output cycle if an earlier line had started and that line delivered fewer than 2493 samples. In every other case it is 0.
- R9: While `in_valid` is 0, no output is produced and the column count does not advance. `in_sol` is ignored in such cycles.
- R10: Samples accepted after reset but before the first line start marker are tagged as overclock (tag 4) and passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is present this cycle |
| in_sol | input | 1 | Marks the first sample of a line (qualified by in_valid) |
| in_data | input | DW | Digitized sample |
| out_valid | output | 1 | Output sample is present |
| out_data | output | DW | Dark-clamped active value or unchanged sample |
| out_tag | output | 3 | Column class: 0 dummy, 1 dark, 2 buffer, 3 active, 4 overclock |
| err_short | output | 1 | Previous line ended before its last active column |

## Verification
The embedded properties assume that `in_valid` is held low while reset is asserted. They also assume that `in_data` is meaningful whenever `in_valid` is high, and that `in_sol` only marks column 0 of a line. The stimulus changes inputs only on the falling clock edge and keeps `in_valid` low through reset. It places `in_sol` on the first sample of each line. In a few idle cycles it deliberately raises `in_sol` without `in_valid`, to show that a marker without a sample is ignored. The dark bands use small values that differ from line to line. The excluded positions carry near-full-scale values, so any leak of an excluded sample into the dark level would show up in the active outputs.

// File: rtl/hdc_pkg.sv
`timescale 1ns/1ps
package hdc_pkg;
   typedef enum logic [2:0] {
      TAG_DUMMY = 3'd0,
      TAG_DARK  = 3'd1,
      TAG_BUF   = 3'd2,
      TAG_ACT   = 3'd3,
      TAG_OVCLK = 3'd4
   } hdc_tag_e;
endpackage

// File: rtl/hdc_col_track.sv
`timescale 1ns/1ps
module hdc_col_track
   import hdc_pkg::*;
#(
   parameter int DUMMY_N   = 11,
   parameter int DARK_N    = 22,
   parameter int DARK_TRIM = 1,
   parameter int BUF_N     = 12,
   parameter int ACT_N     = 2448
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_valid,
   input  logic     in_sol,
   output hdc_tag_e tag,
   output logic     trusted,
   output logic     dark_end,
   output logic     err_short
);
   localparam int DARK_LO = DUMMY_N;
   localparam int BUF_LO  = DUMMY_N + DARK_N;
   localparam int ACT_LO  = BUF_LO + BUF_N;
   localparam int TOTAL   = ACT_LO + ACT_N;
   localparam int TR_LO   = DARK_LO + DARK_TRIM;
   localparam int TR_END  = BUF_LO - DARK_TRIM;
   localparam int CW      = $clog2(TOTAL + 1);

   localparam logic [CW-1:0] C_DARK_LO   = CW'(DARK_LO);
   localparam logic [CW-1:0] C_BUF_LO    = CW'(BUF_LO);
   localparam logic [CW-1:0] C_ACT_LO    = CW'(ACT_LO);
   localparam logic [CW-1:0] C_TOTAL     = CW'(TOTAL);
   localparam logic [CW-1:0] C_TR_LO     = CW'(TR_LO);
   localparam logic [CW-1:0] C_TR_END    = CW'(TR_END);
   localparam logic [CW-1:0] C_DARK_LAST = CW'(BUF_LO - 1);

   logic [CW-1:0] col_q;
   logic [CW-1:0] col_now;
   logic          started_q;
   logic          err_q;

   always_comb begin
      col_now = in_sol ? '0 : col_q;
      if (col_now < C_DARK_LO)      tag = TAG_DUMMY;
      else if (col_now < C_BUF_LO)  tag = TAG_DARK;
      else if (col_now < C_ACT_LO)  tag = TAG_BUF;
      else if (col_now < C_TOTAL)   tag = TAG_ACT;
      else                          tag = TAG_OVCLK;
      trusted  = (col_now >= C_TR_LO) && (col_now < C_TR_END);
      dark_end = (col_now == C_DARK_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q     <= C_TOTAL;
         started_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         err_q <= in_valid && in_sol && started_q && (col_q < C_TOTAL);
         if (in_valid) begin
            col_q <= (col_now == C_TOTAL) ? C_TOTAL : col_now + 1'b1;
            if (in_sol) started_q <= 1'b1;
         end
      end
   end

   assign err_short = err_q;

   // R7
   sol_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sol) |=> (col_q == CW'(1)));

   // R8
   err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_short |-> $past(in_valid && in_sol));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(col_q));
endmodule

// File: rtl/hdc_dark_level.sv
`timescale 1ns/1ps
module hdc_dark_level #(
   parameter int DW          = 12,
   parameter int TRUST_N     = 20,
   parameter int RECIP_SHIFT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sol,
   input  logic          trusted,
   input  logic          dark_end,
   input  logic [DW-1:0] in_data,
   output logic [DW-1:0] level
);
   localparam int MAXV    = (1 << DW) - 1;
   localparam int SUM_MAX = TRUST_N * MAXV;
   localparam int SW      = $clog2(SUM_MAX + 1);

   logic [SW-1:0] sum_q;
   logic [SW-1:0] sum_next;
   logic [DW-1:0] lvl_calc;
   logic [DW-1:0] level_q;

   always_comb begin
      sum_next = (in_sol ? '0 : sum_q) + (trusted ? SW'(in_data) : '0);
   end

   generate
      if ((TRUST_N & (TRUST_N - 1)) == 0) begin : g_pow2
         localparam int LG = $clog2(TRUST_N);
         logic [SW:0] rnd;
         assign rnd      = {1'b0, sum_q} + (SW+1)'(TRUST_N / 2);
         assign lvl_calc = rnd[LG +: DW];
      end else begin : g_recip
         localparam int RECIP = ((1 << RECIP_SHIFT) + TRUST_N / 2) / TRUST_N;
         localparam int RW    = $clog2(RECIP + 1);
         localparam int PW    = SW + RW + 1;
         logic [PW-1:0] prod;
         assign prod     = PW'(sum_q) * PW'(RECIP) + PW'(1 << (RECIP_SHIFT - 1));
         assign lvl_calc = prod[RECIP_SHIFT +: DW];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q   <= '0;
         level_q <= '0;
      end else if (in_valid) begin
         sum_q <= sum_next;
         if (dark_end) level_q <= lvl_calc;
      end
   end

   assign level = level_q;

   // R4
   sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_q <= SW'(SUM_MAX));

   // R6
   excl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sol && !trusted) |=> $stable(sum_q));

   // R4
   level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && dark_end) |=> $stable(level));
endmodule

// File: rtl/hdc_out_stage.sv
`timescale 1ns/1ps
module hdc_out_stage
   import hdc_pkg::*;
#(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  hdc_tag_e      tag,
   input  logic [DW-1:0] level,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output hdc_tag_e      out_tag
);
   logic [DW:0]   diff;
   logic [DW-1:0] clamped;

   always_comb begin
      diff    = {1'b0, in_data} - {1'b0, level};
      clamped = diff[DW] ? '0 : diff[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_tag   <= TAG_DUMMY;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_tag  <= tag;
            out_data <= (tag == TAG_ACT) ? clamped : in_data;
         end
      end
   end

   // R5
   act_le_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_tag == TAG_ACT) |-> (out_data <= $past(in_data)));

   // R3
   pass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_tag != TAG_ACT) |-> (out_data == $past(in_data)));

   // R9
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
endmodule

// File: rtl/hline_dark_clamp.sv
`timescale 1ns/1ps
module hline_dark_clamp
   import hdc_pkg::*;
#(
   parameter int DW          = 12,
   parameter int DUMMY_N     = 11,
   parameter int DARK_N      = 22,
   parameter int DARK_TRIM   = 1,
   parameter int BUF_N       = 12,
   parameter int ACT_N       = 2448,
   parameter int RECIP_SHIFT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sol,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic [2:0]    out_tag,
   output logic          err_short
);
   localparam int TRUST_N = DARK_N - 2 * DARK_TRIM;

   initial begin
      assert (DW >= 2) else $error("DW too small");
      assert (DUMMY_N >= 1) else $error("DUMMY_N must be at least 1");
      assert (DARK_TRIM >= 1) else $error("DARK_TRIM must be at least 1");
      assert (TRUST_N >= 1) else $error("no trusted dark columns left");
      assert (ACT_N >= 1) else $error("ACT_N must be at least 1");
      assert (RECIP_SHIFT >= 2 && RECIP_SHIFT <= 24) else $error("RECIP_SHIFT out of range");
   end

   hdc_tag_e      cls;
   hdc_tag_e      tag_q;
   logic          trusted;
   logic          dark_end;
   logic [DW-1:0] level;

   hdc_col_track #(
      .DUMMY_N  (DUMMY_N),
      .DARK_N   (DARK_N),
      .DARK_TRIM(DARK_TRIM),
      .BUF_N    (BUF_N),
      .ACT_N    (ACT_N)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sol   (in_sol),
      .tag      (cls),
      .trusted  (trusted),
      .dark_end (dark_end),
      .err_short(err_short)
   );

   hdc_dark_level #(
      .DW         (DW),
      .TRUST_N    (TRUST_N),
      .RECIP_SHIFT(RECIP_SHIFT)
   ) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .in_sol  (in_sol),
      .trusted (trusted),
      .dark_end(dark_end),
      .in_data (in_data),
      .level   (level)
   );

   hdc_out_stage #(
      .DW(DW)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .tag      (cls),
      .level    (level),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_tag  (tag_q)
   );

   assign out_tag = tag_q;

   // R8
   err_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_short |-> (out_valid && tag_q == TAG_DUMMY));
endmodule

// File: tb/hline_dark_clamp_bench.sv
`timescale 1ns/1ps
module hline_dark_clamp_bench;
   localparam int TOTAL = 2493;

   typedef struct {
      logic [11:0] d;
      logic [2:0]  t;
      logic        e;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sol = 1'b0;
   logic [11:0] in_data = '0;
   logic        out_valid;
   logic [11:0] out_data;
   logic [2:0]  out_tag;
   logic        err_short;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit started = 1'b0;
   int prev_len = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   hline_dark_clamp u_hline_dark_clamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sol   (in_sol),
      .in_data  (in_data),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_tag  (out_tag),
      .err_short(err_short)
   );

   function automatic logic [2:0] etag(int c);
      if (c < 11) return 3'd0;
      if (c < 33) return 3'd1;
      if (c < 45) return 3'd2;
      if (c < TOTAL) return 3'd3;
      return 3'd4;
   endfunction

   function automatic logic [11:0] pix(int ln, int c);
      if (c >= 12 && c <= 31) return 12'(200 * ln + 3 * c);
      if (c >= 45 && c < TOTAL) return 12'((c * 37 + ln * 101) % 1500);
      return 12'(4095 - (c % 7));
   endfunction

   task automatic idle_cycle(bit stray_sol);
      @(negedge clk);
      in_valid = 1'b0;
      in_sol   = stray_sol;
      in_data  = 12'hABC;
   endtask

   task automatic send_presol(int n);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         @(negedge clk);
         in_valid = 1'b1;
         in_sol   = 1'b0;
         in_data  = 12'(4000 + i);
         // R10: before any marker every sample is overclock and raw
         e.d = in_data; e.t = 3'd4; e.e = 1'b0;
         q.push_back(e);
      end
   endtask

   task automatic send_line(int ln, int len, int gap_every);
      longint s = 0;
      int lvl;
      for (int c = 12; c <= 31; c++) s += longint'(pix(ln, c));
      lvl = int'((s * 3277 + 32768) >> 16);
      for (int c = 0; c < len; c++) begin
         exp_t e;
         int v;
         @(negedge clk);
         in_valid = 1'b1;
         in_sol   = (c == 0);
         in_data  = pix(ln, c);
         v = int'(in_data);
         e.t = etag(c);
         e.d = (e.t == 3'd3) ? ((v > lvl) ? 12'(v - lvl) : 12'd0) : in_data;
         e.e = (c == 0) && started && (prev_len < TOTAL);
         q.push_back(e);
         if (gap_every > 0 && (c % gap_every) == gap_every - 1)
            idle_cycle(c[0]);
      end
      started  = 1'b1;
      prev_len = len;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R9 unexpected output: actual data=%0d tag=%0d expected none",
                        out_data, out_tag);
            end else begin
               exp_t e;
               e = q.pop_front();
               checks++;
               if (out_tag !== e.t) begin
                  errors++;
                  $display("FAIL R2 tag: actual %0d expected %0d", out_tag, e.t);
               end else if (out_data !== e.d) begin
                  errors++;
                  if (e.t == 3'd3)
                     $display("FAIL R5 R4 R6 R7 active data: actual %0d expected %0d",
                              out_data, e.d);
                  else
                     $display("FAIL R3 raw data: actual %0d expected %0d", out_data, e.d);
               end else if (err_short !== e.e) begin
                  errors++;
                  $display("FAIL R8 err_short: actual %0b expected %0b", err_short, e.e);
               end
            end
         end else if (err_short) begin
            checks++; errors++;
            $display("FAIL R8 err_short without output: actual 1 expected 0");
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs quiet in reset
      checks++;
      if (out_valid !== 1'b0 || err_short !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset: actual valid=%0b err=%0b expected 0 0", out_valid, err_short);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || err_short !== 1'b0) begin
         errors++;
         $display("FAIL R1 after reset: actual valid=%0b err=%0b expected 0 0", out_valid, err_short);
      end
      idle_cycle(1'b1);           // R9: stray marker without a sample
      send_presol(5);             // R10
      idle_cycle(1'b0);
      send_line(1, 2497, 0);      // full line plus overclock, first marker: no error
      send_line(2, 100, 7);       // short line with gaps (R9)
      send_line(3, TOTAL, 0);     // R8: previous line short -> error
      send_line(4, 1, 0);         // previous exact length -> no error
      send_line(5, 2600, 13);     // R8 error, new dark level (R7), overclock tail
      send_line(6, 40, 0);        // previous long line -> no error
      idle_cycle(1'b0);
      repeat (5) idle_cycle(1'b0);
      // R9: every accepted sample produced exactly one output
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R9 missing outputs: actual %0d pending expected 0", q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule